// File: doc/BRIEF.md
# Packet-Driven Functional Self-Test Controller

This block runs a functional consistency test on an arithmetic unit. Command packets from a network interface load test vectors into five internal vector buffers. A start command then drives every buffered row into the unit under test. The unit sees two 64-bit operands, a 6-bit opcode and a 2-bit rounding mode, and the transfer follows a valid/retry handshake. Results can come back in any order. Each result is placed in the row named by its returned tag, so the stored results stay in issue order.

The whole run repeats a programmed number of times. The first pass fills two 32-bit result buffers. Every later pass compares each returned result with the stored first-pass value, and any difference sets a sticky error flag. After the last pass the controller streams the stored results out on its own, as two 32-bit words per row, low word first.

Short tests must be padded with no-operation vectors, because all rows run on every pass. A run cannot be interrupted once it has started.

Top module: `pkt_selftest`

## Requirements
- R1: Packet opcodes are encoded as follows: FILL=1, STOP_FILL=2, TEST=3, ITER=4, GO=5. FILL opens a load window and STOP_FILL closes it. TEST writes a buffer only while that window is open. FILL, STOP_FILL and GO ignore their payload.
- R2: A TEST payload is laid out as follows: data in bits 31:0, row in bits 41:32, bank in bits 44:42, and bits 47:45 must be zero. The banks are: 0 operand-1 low word, 1 operand-1 high word, 2 operand-2 low word, 3 operand-2 high word, 4 control word (opcode in bits 5:0, rounding mode in bits 7:6). A TEST with a bank value above 4, or with a row of 128 or more, writes nothing.
- R3: ITER, accepted only while idle, sets the pass count from payload bits 9:0. Values 0 and 1 become 2, and the count is 2 after reset.
- R4: GO, accepted only while idle, starts a run. Every pass issues all 128 rows in ascending order, the tag equals the row, and each run issues exactly 128 × pass-count vectors.
- R5: While valid is high and retry is asserted, valid, tag and all operand fields hold. The row advances only when a vector is consumed.
- R6: Each result is stored at the row given by its returned tag, whatever the order of return. The result input is never back-pressured.
- R7: From the second pass on, every result is compared with the first pass's result for the same row. A mismatch sets the error flag two cycles after the result arrives. The flag stays set until the next accepted GO clears it.
- R8: After the last pass, 256 words stream out on consecutive cycles: row 0 low, row 0 high, row 1 low, and so on. No vector is issued while the stream runs.
- R9: Packets that arrive during a run or during the result stream have no effect.
- R10: After reset, the vector valid, the output valid and the error flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Command packet present this cycle |
| pktOp | input | 3 | Command opcode |
| pktPayload | input | 48 | Command payload |
| dutRetry | input | 1 | Unit cannot take the presented vector |
| dutReady | input | 1 | Unit presents a result this cycle |
| dutResult | input | 64 | Returned result |
| dutRetTag | input | 7 | Row tag of the returned result |
| dutSrc1 | output | 64 | Operand 1 |
| dutSrc2 | output | 64 | Operand 2 |
| dutOp | output | 6 | Operation code for the unit |
| dutRound | output | 2 | Rounding mode for the unit |
| dutValid | output | 1 | Vector valid |
| dutTag | output | 7 | Row tag of the presented vector |
| outValid | output | 1 | Result stream word valid |
| outData | output | 32 | Result stream word |
| errFlag | output | 1 | Sticky pass-to-pass mismatch flag |

## Verification
The stub unit under test asserts retry in an irregular pattern, returns results with a latency that depends on the tag, and so reorders them. A controller that advanced past a retried vector would show up as a content or order mismatch. A controller that stored results by arrival order would stream them in the wrong rows. One run corrupts a single late pass, which must set the flag while the streamed first-pass results stay clean; a following clean run must clear it. Stray TEST packets go outside the window, to bank 5 and to row 128, and a burst of commands is sent in the middle of a run. A design that honoured any of these would corrupt the vectors, the pass count or the stream.

// File: rtl/pkt_selftest_pkg.sv
package pkt_selftest_pkg;
  localparam int PAY_W     = 48;
  localparam int HI_LSB    = 32;   // payload bits above this go to the controller
  localparam int HI_W      = PAY_W - HI_LSB;
  localparam int ROWF_W    = 10;   // row field width inside the upper slice
  localparam int OPC_W     = 6;
  localparam int RND_W     = 2;
  localparam int CTL_W     = OPC_W + RND_W;
  localparam int NUM_DBANK = 4;    // operand banks; the control bank follows
  localparam int CTL_BANK  = NUM_DBANK;
  localparam int MIN_ITER  = 2;

  typedef enum logic [2:0] {
    PKT_NONE = 3'd0,
    PKT_FILL = 3'd1,
    PKT_STOP = 3'd2,
    PKT_TEST = 3'd3,
    PKT_ITER = 3'd4,
    PKT_GO   = 3'd5
  } pkt_op_e;

  typedef struct packed {
    logic wrEn;       // buffer write from a TEST packet
    logic issueLoad;  // output register may load a new vector
    logic capture;    // first pass: store result by tag
    logic compare;    // later pass: compare result by tag
    logic sendEn;     // stream one result word
    logic clearErr;   // run accepted
  } stc_strobe_t;
endpackage

// File: rtl/pkt_selftest_ctrl.sv
module pkt_selftest_ctrl
  import pkt_selftest_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int ITER_W = 10,
  localparam int ROW_W = $clog2(ROWS),
  localparam int CNT_W = ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pktValid,
  input  logic [2:0]        pktOp,
  input  logic [HI_W-1:0]   cmdHi,
  input  logic [ITER_W-1:0] cmdIter,
  input  logic              dutRetry,
  input  logic              dutReady,
  output stc_strobe_t       strobe,
  output logic [2:0]        wrBank,
  output logic [ROW_W-1:0]  wrRow,
  output logic [ROW_W-1:0]  issueRow,
  output logic [CNT_W-1:0]  sendIdx,
  output logic              dutValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RUN, ST_SEND} state_e;

  state_e            state;
  logic [CNT_W-1:0]  issueCnt;
  logic [CNT_W-1:0]  retCnt;
  logic [CNT_W-1:0]  sendCnt;
  logic [ITER_W-1:0] iterIdx;
  logic [ITER_W-1:0] iterTarget;

  pkt_op_e           opE;
  logic [ROWF_W-1:0] rowField;
  logic [HI_W-ROWF_W-1:0] bankField;
  logic              issueMore;
  logic              lastRet;
  logic              lastPass;
  logic [ITER_W-1:0] iterClamped;

  always_comb begin
    opE         = pkt_op_e'(pktOp);
    rowField    = cmdHi[ROWF_W-1:0];
    bankField   = cmdHi[HI_W-1:ROWF_W];
    issueMore   = issueCnt < CNT_W'(ROWS);
    lastRet     = (state == ST_RUN) && dutReady && (retCnt == CNT_W'(ROWS - 1));
    lastPass    = iterIdx == (iterTarget - 1'b1);
    iterClamped = (cmdIter < ITER_W'(MIN_ITER)) ? ITER_W'(MIN_ITER) : cmdIter;

    strobe.wrEn      = pktValid && (state == ST_FILL) && (opE == PKT_TEST)
                       && (bankField <= (HI_W-ROWF_W)'(CTL_BANK))
                       && (rowField < ROWF_W'(ROWS));
    strobe.issueLoad = (state == ST_RUN) && (!dutValid || !dutRetry);
    strobe.capture   = (state == ST_RUN) && dutReady && (iterIdx == '0);
    strobe.compare   = (state == ST_RUN) && dutReady && (iterIdx != '0);
    strobe.sendEn    = (state == ST_SEND);
    strobe.clearErr  = pktValid && (state == ST_IDLE) && (opE == PKT_GO);

    wrBank   = bankField[2:0];
    wrRow    = rowField[ROW_W-1:0];
    issueRow = issueCnt[ROW_W-1:0];
    sendIdx  = sendCnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      issueCnt   <= '0;
      retCnt     <= '0;
      sendCnt    <= '0;
      iterIdx    <= '0;
      iterTarget <= ITER_W'(MIN_ITER);
      dutValid   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (pktValid) begin
          if (opE == PKT_FILL) state <= ST_FILL;
          if (opE == PKT_ITER) iterTarget <= iterClamped;
          if (opE == PKT_GO) begin
            state    <= ST_RUN;
            issueCnt <= '0;
            retCnt   <= '0;
            iterIdx  <= '0;
          end
        end
        ST_FILL: if (pktValid && opE == PKT_STOP) state <= ST_IDLE;
        ST_RUN: begin
          if (strobe.issueLoad) begin
            dutValid <= issueMore;
            if (issueMore) issueCnt <= issueCnt + 1'b1;
          end
          if (dutReady) begin
            if (lastRet) begin
              retCnt <= '0;
              if (lastPass) begin
                state   <= ST_SEND;
                sendCnt <= '0;
              end else begin
                iterIdx  <= iterIdx + 1'b1;
                issueCnt <= '0;
              end
            end else begin
              retCnt <= retCnt + 1'b1;
            end
          end
        end
        ST_SEND: begin
          sendCnt <= sendCnt + 1'b1;
          if (sendCnt == CNT_W'(2 * ROWS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_selftest_dp.sv
module pkt_selftest_dp
  import pkt_selftest_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS),
  localparam int CNT_W = ROW_W + 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stc_strobe_t       strobe,
  input  logic [2:0]        wrBank,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ROW_W-1:0]  issueRow,
  input  logic [CNT_W-1:0]  sendIdx,
  input  logic [RES_W-1:0]  dutResult,
  input  logic [ROW_W-1:0]  dutRetTag,
  output logic [RES_W-1:0]  dutSrc1,
  output logic [RES_W-1:0]  dutSrc2,
  output logic [OPC_W-1:0]  dutOp,
  output logic [RND_W-1:0]  dutRound,
  output logic [ROW_W-1:0]  dutTag,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              errFlag
);
  logic [DATA_W-1:0] rdWord [NUM_DBANK];
  logic [CTL_W-1:0]  ctlMem [ROWS];
  logic [CTL_W-1:0]  ctlQ;
  logic [DATA_W-1:0] goldWord [2];
  logic [DATA_W-1:0] sendWord [2];
  logic [RES_W-1:0]  newQ;
  logic              cmpValid;
  logic              outSel;

  // operand banks, one per 32-bit word
  for (genvar b = 0; b < NUM_DBANK; b++) begin : g_dbank
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rdQ;
    always_ff @(posedge clk) begin
      if (strobe.wrEn && wrBank == 3'(b)) mem[wrRow] <= wrData;
      if (strobe.issueLoad) rdQ <= mem[issueRow];
    end
    assign rdWord[b] = rdQ;
  end

  // control bank keeps only opcode and rounding mode
  always_ff @(posedge clk) begin
    if (strobe.wrEn && wrBank == 3'(CTL_BANK)) ctlMem[wrRow] <= wrData[CTL_W-1:0];
    if (strobe.issueLoad) begin
      ctlQ   <= ctlMem[issueRow];
      dutTag <= issueRow;
    end
  end

  assign dutSrc1  = {rdWord[1], rdWord[0]};
  assign dutSrc2  = {rdWord[3], rdWord[2]};
  assign dutOp    = ctlQ[OPC_W-1:0];
  assign dutRound = ctlQ[CTL_W-1:OPC_W];

  // result halves: written by tag on the first pass, read for compare and stream
  for (genvar h = 0; h < 2; h++) begin : g_res
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] goldQ;
    logic [DATA_W-1:0] sendQ;
    always_ff @(posedge clk) begin
      if (strobe.capture) mem[dutRetTag] <= dutResult[h*DATA_W +: DATA_W];
      if (strobe.compare) goldQ <= mem[dutRetTag];
      if (strobe.sendEn)  sendQ <= mem[sendIdx[CNT_W-1:1]];
    end
    assign goldWord[h] = goldQ;
    assign sendWord[h] = sendQ;
  end

  always_ff @(posedge clk) begin
    if (strobe.compare) newQ <= dutResult;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpValid <= 1'b0;
      errFlag  <= 1'b0;
      outValid <= 1'b0;
      outSel   <= 1'b0;
    end else begin
      cmpValid <= strobe.compare;
      if (strobe.clearErr) errFlag <= 1'b0;
      else if (cmpValid && ({goldWord[1], goldWord[0]} != newQ)) errFlag <= 1'b1;
      outValid <= strobe.sendEn;
      outSel   <= sendIdx[0];
    end
  end

  assign outData = outSel ? sendWord[1] : sendWord[0];
endmodule

// File: rtl/pkt_selftest.sv
module pkt_selftest
  import pkt_selftest_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int ITER_W = 10,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS),
  localparam int CNT_W = ROW_W + 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pktValid,
  input  logic [2:0]        pktOp,
  input  logic [PAY_W-1:0]  pktPayload,
  input  logic              dutRetry,
  input  logic              dutReady,
  input  logic [RES_W-1:0]  dutResult,
  input  logic [ROW_W-1:0]  dutRetTag,
  output logic [RES_W-1:0]  dutSrc1,
  output logic [RES_W-1:0]  dutSrc2,
  output logic [OPC_W-1:0]  dutOp,
  output logic [RND_W-1:0]  dutRound,
  output logic              dutValid,
  output logic [ROW_W-1:0]  dutTag,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              errFlag
);
  stc_strobe_t      strobe;
  logic [2:0]       wrBank;
  logic [ROW_W-1:0] wrRow;
  logic [ROW_W-1:0] issueRow;
  logic [CNT_W-1:0] sendIdx;

  pkt_selftest_ctrl #(.ROWS(ROWS), .ITER_W(ITER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pktValid(pktValid), .pktOp(pktOp),
    .cmdHi(pktPayload[PAY_W-1:HI_LSB]), .cmdIter(pktPayload[ITER_W-1:0]),
    .dutRetry(dutRetry), .dutReady(dutReady),
    .strobe(strobe), .wrBank(wrBank), .wrRow(wrRow),
    .issueRow(issueRow), .sendIdx(sendIdx), .dutValid(dutValid)
  );

  pkt_selftest_dp #(.ROWS(ROWS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrBank(wrBank), .wrRow(wrRow), .wrData(pktPayload[DATA_W-1:0]),
    .issueRow(issueRow), .sendIdx(sendIdx),
    .dutResult(dutResult), .dutRetTag(dutRetTag),
    .dutSrc1(dutSrc1), .dutSrc2(dutSrc2), .dutOp(dutOp), .dutRound(dutRound),
    .dutTag(dutTag), .outValid(outValid), .outData(outData), .errFlag(errFlag)
  );
endmodule

// File: rtl/pkt_selftest_checker.sv
module pkt_selftest_checker #(
  parameter int ROWS   = 128,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dutValid,
  input logic             dutRetry,
  input logic [ROW_W-1:0] dutTag,
  input logic [63:0]      dutSrc1,
  input logic [63:0]      dutSrc2,
  input logic [5:0]       dutOp,
  input logic             dutReady,
  input logic             outValid,
  input logic             errFlag
);
  // R5: a retried vector stays on the port unchanged
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dutValid && dutRetry |=> dutValid && $stable(dutTag) && $stable(dutSrc1)
                             && $stable(dutSrc2) && $stable(dutOp));

  // R4: after a consumed vector, the next one carries the following row
  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dutValid && !dutRetry && (dutTag != ROW_W'(ROWS - 1))
      |=> !dutValid || (dutTag == ROW_W'($past(dutTag) + 1'b1)));

  // R8: streaming and issuing never overlap
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !dutValid);

  // R7: the flag only rises two cycles after a returned result
  assert_errcause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errFlag) |-> $past(dutReady, 2));
endmodule

bind pkt_selftest pkt_selftest_checker #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dutValid(dutValid), .dutRetry(dutRetry),
  .dutTag(dutTag), .dutSrc1(dutSrc1), .dutSrc2(dutSrc2), .dutOp(dutOp),
  .dutReady(dutReady), .outValid(outValid), .errFlag(errFlag)
);

// File: tb/pkt_selftest_bench.sv
module pkt_selftest_bench;
  localparam int ROWS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pktValid = 1'b0;
  logic [2:0]  pktOp = '0;
  logic [47:0] pktPayload = '0;
  logic        dutRetry = 1'b0;
  logic        dutReady = 1'b0;
  logic [63:0] dutResult = '0;
  logic [6:0]  dutRetTag = '0;
  logic [63:0] dutSrc1, dutSrc2;
  logic [5:0]  dutOp;
  logic [1:0]  dutRound;
  logic        dutValid;
  logic [6:0]  dutTag;
  logic        outValid;
  logic [31:0] outData;
  logic        errFlag;

  always #2 clk = ~clk;

  pkt_selftest u_pkt_selftest (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktOp(pktOp),
    .pktPayload(pktPayload), .dutRetry(dutRetry), .dutReady(dutReady),
    .dutResult(dutResult), .dutRetTag(dutRetTag), .dutSrc1(dutSrc1),
    .dutSrc2(dutSrc2), .dutOp(dutOp), .dutRound(dutRound), .dutValid(dutValid),
    .dutTag(dutTag), .outValid(outValid), .outData(outData), .errFlag(errFlag)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] expBank [5][ROWS];
  logic [31:0] expQ [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int t);
    return ({expBank[1][t], expBank[0][t]} + {expBank[3][t], expBank[2][t]})
           ^ {56'd0, expBank[4][t][7:0]};
  endfunction

  // ---------------- stub unit under test ----------------
  logic [63:0] pendRes [ROWS];
  int          pendDue [ROWS];
  bit          pendOn  [ROWS];
  int          cycle = 0;
  int          acceptCnt = 0, orderErr = 0, contentErr = 0, corruptIter = -1;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    logic r;
    int t, passNo;
    logic [63:0] res;
    bit found;
    cycle++;
    if (!rst_n) begin
      dutRetry = 1'b0;
      dutReady = 1'b0;
      for (int i = 0; i < ROWS; i++) pendOn[i] = 0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = (lfsr[1:0] == 2'b00);
      dutRetry = r;
      if (dutValid && !r) begin
        t = int'(dutTag);
        passNo = acceptCnt / ROWS;
        if (t != acceptCnt % ROWS) orderErr++;
        if (dutSrc1 != {expBank[1][t], expBank[0][t]} ||
            dutSrc2 != {expBank[3][t], expBank[2][t]} ||
            dutOp != expBank[4][t][5:0] || dutRound != expBank[4][t][7:6])
          contentErr++;
        res = model(t);
        if (passNo == corruptIter) res = res ^ 64'h80;
        pendRes[t] = res;
        pendOn[t]  = 1;
        pendDue[t] = cycle + 2 + ((t * 7 + passNo * 3) % 11);
        acceptCnt++;
      end
      dutReady = 1'b0;
      found = 0;
      for (int i = 0; i < ROWS; i++) begin
        if (!found && pendOn[i] && pendDue[i] <= cycle) begin
          found = 1;
          pendOn[i] = 0;
          dutReady = 1'b1;
          dutResult = pendRes[i];
          dutRetTag = 7'(i);
        end
      end
    end
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (expQ.size() == 0) check(0, "R8 unexpected stream word", 64'(outData), 64'd0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(outData == e, "R6 R8 stream word", 64'(outData), 64'(e));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic sendPkt(input logic [2:0] op, input logic [47:0] pay);
    @(negedge clk);
    pktValid = 1'b1; pktOp = op; pktPayload = pay;
    @(negedge clk);
    pktValid = 1'b0; pktOp = 3'd0; pktPayload = '0;
  endtask

  function automatic logic [47:0] testPay(input int bank, input int row, input logic [31:0] d);
    return {3'b000, 3'(bank), 10'(row), d};
  endfunction

  task automatic fill(input logic [31:0] seed);
    sendPkt(3'd1, 48'hFFFF_FFFF_FFFF);
    for (int b = 0; b < 5; b++)
      for (int r = 0; r < ROWS; r++) begin
        expBank[b][r] = (32'(r) * 32'h9E3779B1) ^ (32'(b) << 28) ^ (seed * 32'h85EBCA6B);
        sendPkt(3'd3, testPay(b, r, expBank[b][r]));
      end
    sendPkt(3'd2, 48'hFFFF_FFFF_FFFF);
  endtask

  task automatic runGo(input int iters, input int corrupt, input bit expErr,
                       input bit midNoise, input string tag);
    acceptCnt = 0; orderErr = 0; contentErr = 0; corruptIter = corrupt;
    for (int r = 0; r < ROWS; r++) begin
      logic [63:0] m;
      m = model(r);
      expQ.push_back(m[31:0]);
      expQ.push_back(m[63:32]);
    end
    sendPkt(3'd5, 48'hFFFF_FFFF_FFFF);
    if (midNoise) begin
      repeat (20) @(negedge clk);
      sendPkt(3'd4, 48'd7);
      sendPkt(3'd1, 48'd0);
      sendPkt(3'd3, testPay(0, 0, 32'hDEAD_BEEF));
      sendPkt(3'd2, 48'd0);
      sendPkt(3'd5, 48'd0);
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(acceptCnt == ROWS * iters, {tag, " R3 R4 vectors issued"}, 64'(acceptCnt), 64'(ROWS * iters));
    check(orderErr == 0, {tag, " R4 issue order"}, 64'(orderErr), 64'd0);
    check(contentErr == 0, {tag, " R2 R5 vector content"}, 64'(contentErr), 64'd0);
    check(errFlag == expErr, {tag, " R7 error flag"}, 64'(errFlag), 64'(expErr));
    check(outValid == 1'b0, {tag, " R8 stream ended"}, 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(dutValid == 1'b0, "R10 reset vector valid", 64'(dutValid), 64'd0);
    check(outValid == 1'b0, "R10 reset output valid", 64'(outValid), 64'd0);
    check(errFlag == 1'b0, "R10 reset error flag", 64'(errFlag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(32'h1);
    runGo(2, -1, 1'b0, 1'b0, "default passes");

    // R1 R2: ignored TEST packets (outside window, bank 5, row 128)
    sendPkt(3'd3, testPay(0, 5, 32'h1111_1111));
    sendPkt(3'd1, 48'd0);
    sendPkt(3'd3, testPay(5, 3, 32'h2222_2222));
    sendPkt(3'd3, testPay(0, 128, 32'h3333_3333));
    sendPkt(3'd3, {3'b001, 3'd0, 10'd9, 32'h4444_4444});
    sendPkt(3'd2, 48'd0);
    runGo(2, -1, 1'b0, 1'b0, "R1 R2 ignored writes");

    sendPkt(3'd4, 48'd5);
    runGo(5, 3, 1'b1, 1'b0, "R7 corrupt pass");

    sendPkt(3'd4, 48'd1);
    runGo(2, -1, 1'b0, 1'b0, "R3 clamp and R7 clear");

    runGo(2, -1, 1'b0, 1'b1, "R9 noise during run");
    runGo(2, -1, 1'b0, 1'b0, "R9 after noise");

    fill(32'h5A5A_0F0F);
    sendPkt(3'd4, 48'd3);
    runGo(3, -1, 1'b0, 1'b0, "refill three passes");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule